// File: doc/BRIEF.md
# PCIe Advanced Error Reporting Register Block

This block holds the advanced error reporting capability for one PCIe function. It sits in the extended part of configuration space and takes single-cycle error pulses from the rest of the function. The pulses arrive as two vectors, one for uncorrectable sources and one for correctable sources. Each pulse comes with the 128-bit header of the transaction that caused it. Every pulse sets a sticky status bit. When the matching mask bit is clear, the block also raises a one-cycle request on one of three message outputs: correctable, non-fatal or fatal. For an uncorrectable source, a per-bit severity register decides between fatal and non-fatal.

The first uncorrectable error after the capture logic is armed is recorded in two places. Its bit index goes into a pointer register and its header goes into a four-dword log. Both stay frozen until software clears the status bit that the pointer names. The capture logic is a two-state machine. In `FE_ARMED`, any uncorrectable pulse takes the `capture` transition to `FE_HELD`. In `FE_HELD`, a write-1-to-clear that hits the pointed bit, with no new pulse on that bit in the same cycle, takes the `rearm` transition back to `FE_ARMED`.

Software reaches the registers through a dword config port. The read side is a second two-state machine. `ACC_IDLE` moves to `ACC_RESP` on a read request, and `ACC_RESP` returns to `ACC_IDLE` when no read follows. `ACC_RESP` presents the data with a valid flag.

Top module: `aer_regfile`

## Requirements
- R1: After reset, both status registers read 0, both masks read 0 and the severity register reads 0x00062030. The pointer and all four log dwords read 0, and the message outputs and `cfg_rvalid` are low.
- R2: Byte offset 0x100 reads 0x14010001. This is capability ID 0x0001 in bits 15:0, version 1 in bits 19:16 and next-capability offset 0x140 in bits 31:20. Writes to this offset have no effect.
- R3: An error pulse sets the status bit with the same index, whatever the mask. Uncorrectable status is at 0x104 (bits UE_W-1:0) and correctable status is at 0x110 (bits CE_W-1:0). A status bit stays set until it is cleared by a write. If a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R4: Writing a 1 to a status bit clears that bit. Writing a 0 leaves it unchanged.
- R5: Uncorrectable mask (0x108), severity (0x10C) and correctable mask (0x114) are read/write. Only bits UE_W-1:0 or CE_W-1:0 are stored. Higher bits read 0.
- R6: A correctable pulse whose mask bit was clear before the clock edge makes `msg_cor` high for exactly the next cycle. A masked pulse gives no message.
- R7: An unmasked uncorrectable pulse makes `msg_fatal` high for the next cycle when its severity bit is 1, and `msg_nonfatal` high when it is 0. A masked pulse gives neither.
- R8: In the armed state, the first cycle with any uncorrectable pulse, masked or not, does two things. It stores the lowest pulsing bit index in 0x118 bits 4:0. It stores the header into 0x11C, 0x120, 0x124 and 0x128, where the dword at 0x11C+4k holds header bits 32k+31:32k.
- R9: While an error is held, later uncorrectable pulses change neither the pointer nor the log.
- R10: A status clear of the pointed bit re-arms capture. No pulse on that bit may arrive in the same cycle. Clearing any other bit does not re-arm.
- R11: The pointer and log are read-only. Offsets 0x12C to 0x13C and offsets outside 0x100 to 0x13C read 0, and writes to them have no effect.
- R12: `cfg_rdata` and `cfg_rvalid` are valid in the cycle after `cfg_rd`. They carry the register contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ue_evt | input | UE_W | Uncorrectable error pulses, one bit per source |
| ce_evt | input | CE_W | Correctable error pulses, one bit per source |
| hdr_in | input | 128 | Header of the transaction behind this cycle's pulses |
| cfg_rd | input | 1 | Dword read request |
| cfg_wr | input | 1 | Dword write request |
| cfg_addr | input | ADDR_W | Dword address (byte offset bits 11:2) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| cfg_rvalid | output | 1 | Read data valid |
| msg_cor | output | 1 | Correctable message request |
| msg_nonfatal | output | 1 | Non-fatal message request |
| msg_fatal | output | 1 | Fatal message request |

## Verification
The assertions assume that error pulses are sampled as they stand at the clock edge. They also assume that a read and a write never arrive in the same cycle, which keeps the read response tied only to the preceding read request. The bench drives all inputs on the falling edge and never raises `cfg_rd` and `cfg_wr` together. The directed cases include a pulse and a clear on the same bit in one cycle. A pseudo-random phase mixes pulses, status clears and mask writes, all inside that single-command rule.

// File: rtl/aer_pkg.sv
package aer_pkg;

    localparam int unsigned DWORD_W   = 32;
    localparam int unsigned HDR_W     = 128;
    localparam int unsigned LOG_WORDS = HDR_W / DWORD_W;
    localparam int unsigned NUM_WORDS = 7 + LOG_WORDS;

    localparam logic [15:0] CAP_ID   = 16'h0001;
    localparam logic [3:0]  CAP_VER  = 4'h1;
    localparam logic [11:0] NEXT_OFS = 12'h140;

    // dword address of the capability base (byte 0x100)
    localparam logic [9:0] BASE_DW = 10'h040;

    typedef enum logic [3:0] {
        W_HDR    = 4'd0,
        W_UESTAT = 4'd1,
        W_UEMASK = 4'd2,
        W_UESEV  = 4'd3,
        W_CESTAT = 4'd4,
        W_CEMASK = 4'd5,
        W_FEPTR  = 4'd6,
        W_LOG0   = 4'd7
    } word_e;

    localparam logic [9:0] UESTAT_DW = BASE_DW + 10'd1;

    typedef enum logic {
        FE_ARMED = 1'b0,
        FE_HELD  = 1'b1
    } fe_state_e;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/aer_src_bank.sv
module aer_src_bank #(
    parameter int unsigned W        = 16,
    parameter logic [31:0] MASK_RST = 32'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] wdata,
    input  logic         wr_stat,
    input  logic         wr_mask,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] mask_q
);

    logic [W-1:0] clr;

    always_comb begin
        clr = wr_stat ? wdata : '0;
    end

    // set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST[W-1:0];
        end else if (wr_mask) begin
            mask_q <= wdata;
        end
    end

endmodule

// File: rtl/aer_fe_capture.sv
module aer_fe_capture
    import aer_pkg::*;
#(
    parameter int unsigned UE_W  = 32,
    localparam int unsigned PTR_W = $clog2(UE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UE_W-1:0]   ue_evt,
    input  logic [UE_W-1:0]   ue_clr,
    input  logic [HDR_W-1:0]  hdr_in,
    output logic              held,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [HDR_W-1:0]  log_q
);

    fe_state_e        fe_q, fe_d;
    logic             any_evt;
    logic             rearm;
    logic             capture;
    logic [PTR_W-1:0] first_idx;

    always_comb begin
        first_idx = '0;
        for (int i = int'(UE_W) - 1; i >= 0; i--) begin
            if (ue_evt[i]) begin
                first_idx = PTR_W'(i);
            end
        end
    end

    always_comb begin
        any_evt = |ue_evt;
        rearm   = ue_clr[ptr_q] && !ue_evt[ptr_q];
    end

    always_comb begin
        fe_d = fe_q;
        unique case (fe_q)
            FE_ARMED: if (any_evt) fe_d = FE_HELD;
            FE_HELD:  if (rearm)   fe_d = FE_ARMED;
            default:               fe_d = FE_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q <= FE_ARMED;
        end else begin
            fe_q <= fe_d;
        end
    end

    always_comb begin
        capture = 1'b0;
        held    = 1'b0;
        unique case (fe_q)
            FE_ARMED: capture = any_evt;
            FE_HELD:  held    = 1'b1;
            default:  capture = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            log_q <= '0;
        end else if (capture) begin
            ptr_q <= first_idx;
            log_q <= hdr_in;
        end
    end

endmodule

// File: rtl/aer_msg_gen.sv
module aer_msg_gen #(
    parameter int unsigned UE_W = 32,
    parameter int unsigned CE_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [UE_W-1:0] ue_evt,
    input  logic [CE_W-1:0] ce_evt,
    input  logic [UE_W-1:0] ue_mask,
    input  logic [UE_W-1:0] ue_sev,
    input  logic [CE_W-1:0] ce_mask,
    output logic            msg_cor,
    output logic            msg_nonfatal,
    output logic            msg_fatal
);

    logic [UE_W-1:0] ue_live;
    logic [CE_W-1:0] ce_live;

    always_comb begin
        ue_live = ue_evt & ~ue_mask;
        ce_live = ce_evt & ~ce_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_cor      <= 1'b0;
            msg_nonfatal <= 1'b0;
            msg_fatal    <= 1'b0;
        end else begin
            msg_cor      <= |ce_live;
            msg_nonfatal <= |(ue_live & ~ue_sev);
            msg_fatal    <= |(ue_live & ue_sev);
        end
    end

endmodule

// File: rtl/aer_cfg_port.sv
module aer_cfg_port
    import aer_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_rd,
    input  logic                                cfg_wr,
    input  logic [ADDR_W-1:0]                   cfg_addr,
    input  logic [NUM_WORDS-1:0][DWORD_W-1:0]   rd_words,
    output logic [NUM_WORDS-1:0]                wr_strobe,
    output logic [DWORD_W-1:0]                  cfg_rdata,
    output logic                                cfg_rvalid
);

    localparam logic [ADDR_W-5:0] BLK_TAG = (ADDR_W-4)'(BASE_DW >> 4);

    logic               hit;
    logic [3:0]         idx;
    logic [DWORD_W-1:0] rd_mux;
    acc_state_e         acc_q, acc_d;

    always_comb begin
        idx = cfg_addr[3:0];
        hit = (cfg_addr[ADDR_W-1:4] == BLK_TAG) && (idx < 4'(NUM_WORDS));
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_strobe
        assign wr_strobe[g] = cfg_wr && hit && (idx == 4'(g));
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < int'(NUM_WORDS); i++) begin
            if (hit && idx == 4'(i)) begin
                rd_mux = rd_words[i];
            end
        end
    end

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            ACC_IDLE: if (cfg_rd)  acc_d = ACC_RESP;
            ACC_RESP: if (!cfg_rd) acc_d = ACC_IDLE;
            default:               acc_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= ACC_IDLE;
        end else begin
            acc_q <= acc_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rd_mux;
        end
    end

    always_comb begin
        cfg_rvalid = 1'b0;
        unique case (acc_q)
            ACC_IDLE: cfg_rvalid = 1'b0;
            ACC_RESP: cfg_rvalid = 1'b1;
            default:  cfg_rvalid = 1'b0;
        endcase
    end

endmodule

// File: rtl/aer_regfile.sv
module aer_regfile
    import aer_pkg::*;
#(
    parameter int unsigned UE_W        = 32,
    parameter int unsigned CE_W        = 16,
    parameter int unsigned ADDR_W      = 10,
    parameter logic [31:0] UE_SEV_RST  = 32'h0006_2030,
    parameter logic [31:0] UE_MASK_RST = 32'h0,
    parameter logic [31:0] CE_MASK_RST = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [UE_W-1:0]     ue_evt,
    input  logic [CE_W-1:0]     ce_evt,
    input  logic [HDR_W-1:0]    hdr_in,
    input  logic                cfg_rd,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DWORD_W-1:0]  cfg_wdata,
    output logic [DWORD_W-1:0]  cfg_rdata,
    output logic                cfg_rvalid,
    output logic                msg_cor,
    output logic                msg_nonfatal,
    output logic                msg_fatal
);

    localparam int unsigned PTR_W = $clog2(UE_W);

    logic [NUM_WORDS-1:0]              wr_strobe;
    logic [NUM_WORDS-1:0][DWORD_W-1:0] rd_words;
    logic [UE_W-1:0]                   ue_stat_q, ue_mask_q, ue_sev_q, ue_clr;
    logic [CE_W-1:0]                   ce_stat_q, ce_mask_q;
    logic                              fe_held;
    logic [PTR_W-1:0]                  fe_ptr;
    logic [HDR_W-1:0]                  hdr_log;

    aer_cfg_port #(.ADDR_W(ADDR_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_rd     (cfg_rd),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .rd_words   (rd_words),
        .wr_strobe  (wr_strobe),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid)
    );

    aer_src_bank #(.W(UE_W), .MASK_RST(UE_MASK_RST)) u_ue_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (ue_evt),
        .wdata   (cfg_wdata[UE_W-1:0]),
        .wr_stat (wr_strobe[W_UESTAT]),
        .wr_mask (wr_strobe[W_UEMASK]),
        .stat_q  (ue_stat_q),
        .mask_q  (ue_mask_q)
    );

    aer_src_bank #(.W(CE_W), .MASK_RST(CE_MASK_RST)) u_ce_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (ce_evt),
        .wdata   (cfg_wdata[CE_W-1:0]),
        .wr_stat (wr_strobe[W_CESTAT]),
        .wr_mask (wr_strobe[W_CEMASK]),
        .stat_q  (ce_stat_q),
        .mask_q  (ce_mask_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ue_sev_q <= UE_SEV_RST[UE_W-1:0];
        end else if (wr_strobe[W_UESEV]) begin
            ue_sev_q <= cfg_wdata[UE_W-1:0];
        end
    end

    always_comb begin
        ue_clr = wr_strobe[W_UESTAT] ? cfg_wdata[UE_W-1:0] : '0;
    end

    aer_fe_capture #(.UE_W(UE_W)) u_fe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ue_evt (ue_evt),
        .ue_clr (ue_clr),
        .hdr_in (hdr_in),
        .held   (fe_held),
        .ptr_q  (fe_ptr),
        .log_q  (hdr_log)
    );

    aer_msg_gen #(.UE_W(UE_W), .CE_W(CE_W)) u_msg (
        .clk          (clk),
        .rst_n        (rst_n),
        .ue_evt       (ue_evt),
        .ce_evt       (ce_evt),
        .ue_mask      (ue_mask_q),
        .ue_sev       (ue_sev_q),
        .ce_mask      (ce_mask_q),
        .msg_cor      (msg_cor),
        .msg_nonfatal (msg_nonfatal),
        .msg_fatal    (msg_fatal)
    );

    always_comb begin
        rd_words                       = '0;
        rd_words[W_HDR]                = {NEXT_OFS, CAP_VER, CAP_ID};
        rd_words[W_UESTAT][UE_W-1:0]   = ue_stat_q;
        rd_words[W_UEMASK][UE_W-1:0]   = ue_mask_q;
        rd_words[W_UESEV][UE_W-1:0]    = ue_sev_q;
        rd_words[W_CESTAT][CE_W-1:0]   = ce_stat_q;
        rd_words[W_CEMASK][CE_W-1:0]   = ce_mask_q;
        rd_words[W_FEPTR][PTR_W-1:0]   = fe_ptr;
        for (int k = 0; k < int'(LOG_WORDS); k++) begin
            rd_words[int'(W_LOG0) + k] = hdr_log[k*DWORD_W +: DWORD_W];
        end
    end

endmodule

// File: rtl/aer_regfile_chk.sv
module aer_regfile_chk
    import aer_pkg::*;
#(
    parameter int unsigned UE_W   = 32,
    parameter int unsigned CE_W   = 16,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned PTR_W = $clog2(UE_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [UE_W-1:0]   ue_evt,
    input logic [CE_W-1:0]   ce_evt,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_rvalid,
    input logic              msg_cor,
    input logic              msg_nonfatal,
    input logic              msg_fatal,
    input logic [UE_W-1:0]   ue_stat_q,
    input logic [CE_W-1:0]   ce_stat_q,
    input logic [UE_W-1:0]   ue_mask_q,
    input logic [UE_W-1:0]   ue_sev_q,
    input logic [CE_W-1:0]   ce_mask_q,
    input logic              fe_held,
    input logic [PTR_W-1:0]  fe_ptr
);

    p_ue_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ue_evt) |=> ((ue_stat_q & $past(ue_evt)) == $past(ue_evt)));

    p_ce_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ce_evt) |=> ((ce_stat_q & $past(ce_evt)) == $past(ce_evt)));

    p_ue_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == ADDR_W'(UESTAT_DW))
        |=> ((ue_stat_q & $past(ue_stat_q)) == $past(ue_stat_q)));

    p_cor_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ce_evt & ~ce_mask_q)) |=> msg_cor);

    p_cor_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(ce_evt & ~ce_mask_q)) |=> !msg_cor);

    p_fatal_msg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ue_evt & ~ue_mask_q & ue_sev_q)) |=> msg_fatal);

    p_nonfatal_msg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ue_evt & ~ue_mask_q & ~ue_sev_q)) |=> msg_nonfatal);

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fe_held && (|ue_evt)) |=> fe_held);

    p_ptr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fe_held |-> ue_stat_q[fe_ptr]);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_held && $past(fe_held)) |-> $stable(fe_ptr));

    p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd));

endmodule

bind aer_regfile aer_regfile_chk #(
    .UE_W   (UE_W),
    .CE_W   (CE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ue_evt       (ue_evt),
    .ce_evt       (ce_evt),
    .cfg_rd       (cfg_rd),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_rvalid   (cfg_rvalid),
    .msg_cor      (msg_cor),
    .msg_nonfatal (msg_nonfatal),
    .msg_fatal    (msg_fatal),
    .ue_stat_q    (ue_stat_q),
    .ce_stat_q    (ce_stat_q),
    .ue_mask_q    (ue_mask_q),
    .ue_sev_q     (ue_sev_q),
    .ce_mask_q    (ce_mask_q),
    .fe_held      (fe_held),
    .fe_ptr       (fe_ptr)
);

// File: tb/aer_regfile_tb_top.sv
module aer_regfile_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  ue_evt = '0;
    logic [15:0]  ce_evt = '0;
    logic [127:0] hdr_in = '0;
    logic         cfg_rd = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [9:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         cfg_rvalid, msg_cor, msg_nonfatal, msg_fatal;

    always #5 clk = ~clk;

    aer_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .ue_evt(ue_evt), .ce_evt(ce_evt),
        .hdr_in(hdr_in), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .msg_cor(msg_cor),
        .msg_nonfatal(msg_nonfatal), .msg_fatal(msg_fatal)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_tag = "";

    // behavioural reference state
    logic [31:0] m_ues, m_uem, m_sev, m_log [4];
    logic [15:0] m_ces, m_cem;
    bit          m_held;
    int          m_ptr;
    bit          e_cor, e_fat, e_nf, e_rv;
    logic [31:0] e_rd;
    logic [11:0] e_off;

    function automatic logic [31:0] mread(logic [11:0] off);
        case (off)
            12'h100: return 32'h1401_0001;
            12'h104: return m_ues;
            12'h108: return m_uem;
            12'h10C: return m_sev;
            12'h110: return {16'h0, m_ces};
            12'h114: return {16'h0, m_cem};
            12'h118: return 32'(m_ptr);
            12'h11C: return m_log[0];
            12'h120: return m_log[1];
            12'h124: return m_log[2];
            12'h128: return m_log[3];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [11:0] off);
        if (cur_tag != "") return cur_tag;
        case (off)
            12'h100:                   return "R2";
            12'h104, 12'h110:          return "R3";
            12'h108, 12'h10C, 12'h114: return "R5";
            12'h118, 12'h11C, 12'h120,
            12'h124, 12'h128:          return "R8";
            default:                   return "R11";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin : model
        logic [11:0] off;
        cyc++;
        off = {cfg_addr, 2'b00};
        if (!rst_n) begin
            m_ues = '0; m_uem = '0; m_sev = 32'h0006_2030;
            m_ces = '0; m_cem = '0; m_held = 1'b0; m_ptr = 0;
            for (int k = 0; k < 4; k++) m_log[k] = '0;
            e_cor = 0; e_fat = 0; e_nf = 0; e_rv = 0; e_rd = '0; e_off = '0;
        end else begin
            e_rv = cfg_rd;
            if (cfg_rd) begin
                e_rd  = mread(off);
                e_off = off;
            end
            e_cor = |(ce_evt & ~m_cem);
            e_fat = |(ue_evt & ~m_uem & m_sev);
            e_nf  = |(ue_evt & ~m_uem & ~m_sev);
            if (m_held) begin
                if (cfg_wr && off == 12'h104 && cfg_wdata[m_ptr] && !ue_evt[m_ptr])
                    m_held = 1'b0;
            end else if (ue_evt != 0) begin
                for (int i = 31; i >= 0; i--) if (ue_evt[i]) m_ptr = i;
                for (int k = 0; k < 4; k++) m_log[k] = hdr_in[k*32 +: 32];
                m_held = 1'b1;
            end
            if (cfg_wr) begin
                case (off)
                    12'h104: m_ues = m_ues & ~cfg_wdata;
                    12'h108: m_uem = cfg_wdata;
                    12'h10C: m_sev = cfg_wdata;
                    12'h110: m_ces = m_ces & ~cfg_wdata[15:0];
                    12'h114: m_cem = cfg_wdata[15:0];
                    default: ;
                endcase
            end
            m_ues = m_ues | ue_evt;
            m_ces = m_ces | ce_evt;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            if (!rst_n) begin
                chk("R1", {28'h0, msg_cor, msg_fatal, msg_nonfatal, cfg_rvalid}, 32'h0);
            end else begin
                chk("R6", 32'(msg_cor), 32'(e_cor));
                chk("R7", 32'(msg_fatal), 32'(e_fat));
                chk("R7", 32'(msg_nonfatal), 32'(e_nf));
                chk("R12", 32'(cfg_rvalid), 32'(e_rv));
                if (e_rv) chk(tag_of(e_off), cfg_rdata, e_rd);
            end
        end
    end

    task automatic drive(logic [31:0] ue, logic [15:0] ce, logic [127:0] h,
                         bit rd, bit wr, logic [11:0] off, logic [31:0] d);
        @(negedge clk);
        ue_evt = ue; ce_evt = ce; hdr_in = h;
        cfg_rd = rd; cfg_wr = wr; cfg_addr = off[11:2]; cfg_wdata = d;
    endtask

    task automatic idle();
        drive('0, '0, '0, 0, 0, 12'h0, '0);
    endtask

    task automatic rd(logic [11:0] off);
        drive('0, '0, '0, 1, 0, off, '0);
    endtask

    task automatic wr(logic [11:0] off, logic [31:0] d);
        drive('0, '0, '0, 0, 1, off, d);
    endtask

    task automatic ev(logic [31:0] ue, logic [15:0] ce, logic [127:0] h);
        drive(ue, ce, h, 0, 0, 12'h0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] ha, hb, hc;
        ha = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        hb = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
        hc = 128'hA5A5_A5A5_5A5A_5A5A_0F0F_0F0F_F0F0_F0F0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";
        for (int a = 12'h100; a <= 12'h128; a += 4) rd(12'(a));
        cur_tag = "R11";
        rd(12'h12C); rd(12'h13C); rd(12'h0FC); rd(12'h140);
        cur_tag = "R2";
        wr(12'h100, 32'hFFFF_FFFF); rd(12'h100);
        cur_tag = "R5";
        wr(12'h108, 32'hFFFF_FFFF); rd(12'h108);
        wr(12'h114, 32'hFFFF_FFFF); rd(12'h114);
        wr(12'h10C, 32'h0000_1234); rd(12'h10C);
        wr(12'h108, 32'h0); wr(12'h10C, 32'h0006_2030); wr(12'h114, 32'h0);

        cur_tag = "R6";
        wr(12'h114, 32'h20);
        ev('0, 16'h0008, '0); idle();
        ev('0, 16'h0020, '0); idle();
        cur_tag = "R3";
        rd(12'h110);

        cur_tag = "R8";
        ev((32'h1 << 4) | (32'h1 << 9), '0, ha); idle();
        rd(12'h118); rd(12'h11C); rd(12'h120); rd(12'h124); rd(12'h128);
        cur_tag = "R9";
        ev(32'h1 << 12, '0, hb); idle();
        rd(12'h118); rd(12'h11C);
        cur_tag = "R10";
        wr(12'h104, 32'h1 << 9);
        ev(32'h1 << 1, '0, hb); idle();
        rd(12'h118); rd(12'h124);
        wr(12'h104, 32'h1 << 4); idle();
        rd(12'h104);
        ev(32'h1 << 20, '0, hc); idle();
        rd(12'h118); rd(12'h128);

        cur_tag = "R11";
        wr(12'h118, 32'hFFFF_FFFF); wr(12'h11C, 32'h0); wr(12'h12C, 32'hFFFF_FFFF);
        rd(12'h118); rd(12'h11C); rd(12'h12C);
        cur_tag = "R4";
        wr(12'h104, 32'h0); rd(12'h104);
        wr(12'h110, 32'h8); rd(12'h110);
        cur_tag = "R3";
        drive(32'h1 << 7, '0, '0, 0, 1, 12'h104, 32'h1 << 7); idle();
        rd(12'h104);

        cur_tag = "R7";
        wr(12'h108, 32'h1 << 5);
        ev(32'h1 << 5, '0, '0); idle();
        ev(32'h1 << 6, '0, '0); idle();
        ev(32'h1 << 13, '0, '0); idle();
        wr(12'h10C, 32'h0);
        ev(32'h1 << 13, '0, '0); idle();
        wr(12'h108, 32'h0); wr(12'h10C, 32'h0006_2030);

        cur_tag = "";
        void'($urandom(32'd11));
        for (int i = 0; i < 800; i++) begin
            logic [31:0] r, ue, d;
            logic [15:0] ce;
            logic [11:0] off;
            r   = $urandom;
            ue  = (r[2:0] == 3'd0) ? (32'h1 << r[7:3]) : 32'h0;
            if (r[9:8] == 2'd0) ue = ue | (32'h1 << r[28:24]);
            ce  = (r[12:10] == 3'd0) ? (16'h1 << r[16:13]) : 16'h0;
            off = 12'h100 + {6'h0, r[23:20], 2'b00};
            d   = $urandom;
            case (r[19:18])
                2'd0: drive(ue, ce, {$urandom, $urandom, $urandom, $urandom}, 1, 0, off, '0);
                2'd1: drive(ue, ce, {$urandom, $urandom, $urandom, $urandom}, 0, 1, off, d);
                2'd2: drive(ue, ce, {$urandom, $urandom, $urandom, $urandom}, 0, 1, 12'h104,
                            (d[0] ? 32'hFFFF_FFFF : (32'h1 << d[5:1])));
                default: drive(ue, ce, {$urandom, $urandom, $urandom, $urandom}, 0, 0, off, '0);
            endcase
        end
        cur_tag = "R12";
        for (int a = 12'h104; a <= 12'h128; a += 4) rd(12'(a));
        idle(); idle(); idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule